// File: doc/BRIEF.md
# Two-Channel PWM Output Override and Fault Stage

This block is the last stage of a two-channel PWM timer. An external counter reports which of four phases it is in (dead time A, on time A, dead time B, on time B) and pulses a strobe whenever that phase changes. From the phase the block drives two waveform outputs, A and B, each with its own output enable. In normal operation, output A is high during on time A and output B is high during on time B. Software can set an override bit to take each output's level from a four-bit per-phase pattern instead. A one-ramp mode lets each output change only during its own two phases.

A fault-control register holds an enable bit and a safe level for each output. Only power-on reset clears this register. The ordinary system reset reloads it from a constant configuration input, so the pins come up in a known safe state. A registered fault input forces every enabled output to its safe level. The same happens after any reset, and in both cases the outputs stay forced until the first phase update that follows. A status flag warns software when override is on and a safe level does not match the pattern bits that surround a fault.

Top module: `pwm_out_stage`

## Requirements
- R1: While `por_rst` is high, every register is cleared at the clock edge. Afterwards both output enables and both outputs are low and `polarity_warn` is low.
- R2: A clock edge with `sys_rst` high (and `por_rst` low) loads the fault-control register from `cfg_default` and clears the override, one-ramp and pattern registers. The fault-control layout is: bit 0 = enable A, bit 1 = enable B, bit 2 = safe level A, bit 3 = safe level B.
- R3: After a reset of either kind, each enabled output shows its safe level until the first clock edge that samples `phase_valid` high.
- R4: `oe_a`/`oe_b` equal the enable bits. While an output's enable is clear, that output is held low, even during a fault.
- R5: Phase encoding is 0 = dead time A, 1 = on time A, 2 = dead time B, 3 = on time B. Without override and without one-ramp, the edge that samples `phase_valid` sets A high only for phase 1 and B high only for phase 3.
- R6: With override set, each output's level after a phase update is bit `phase` of its pattern. Pattern A is register bits [3:0] and pattern B is bits [7:4].
- R7: In one-ramp mode, A is updated only for phases 0 and 1, and B only for phases 2 and 3. On the other output's phases, each output holds its previous level.
- R8: `fault_in` is registered. One edge after it is sampled high, enabled outputs show their safe levels, taking priority over override. They stay forced until a phase update sampled while the registered fault flag is already low.
- R9: `polarity_warn` is high exactly when override is set and, for either output, the safe level differs from bit 0 or bit 2 of that output's pattern.
- R10: Writes take effect at the edge that samples `wr_en`. `wr_sel` selects the register: 0 = fault control (data [3:0]), 1 = control (bit 0 override, bit 1 one-ramp), 2 = patterns. Select 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Synchronous power-on reset, clears everything |
| sys_rst | input | 1 | Synchronous system reset, reloads fault control from configuration |
| cfg_default | input | 4 | Constant fault-control configuration value |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| phase_valid | input | 1 | Counter phase update strobe |
| phase | input | 2 | Current counter phase |
| fault_in | input | 1 | Filtered fault request |
| wo_a | output | 1 | Waveform output A |
| wo_b | output | 1 | Waveform output B |
| oe_a | output | 1 | Output enable A |
| oe_b | output | 1 | Output enable B |
| polarity_warn | output | 1 | Override pattern and safe level mismatch |

## Verification
Each result is due one clock edge after its stimulus is sampled. A register write shows on the enables and the warning flag after the edge that samples the strobe. A phase update changes the outputs after the edge that samples `phase_valid`. A fault request forces the outputs after the edge that samples `fault_in`, and the release needs a further phase update once the registered flag has cleared. The bench drives every input just after a falling edge and samples the outputs at the next falling edge, so exactly one rising edge separates stimulus from check. The release corner is covered with a phase update issued while the registered fault flag is still set.

// File: rtl/pwm_out_pkg.sv
package pwm_out_pkg;
  localparam int NUM_CH    = 2;
  localparam int NUM_PHASE = 4;
  localparam int PHASE_W   = $clog2(NUM_PHASE);
  localparam int FC_W      = 2 * NUM_CH;
  localparam int VAL_W     = NUM_CH * NUM_PHASE;
  localparam int SEL_W     = 2;

  // Safe levels in the upper half, enables in the lower half.
  typedef struct packed {
    logic [NUM_CH-1:0] lvl;
    logic [NUM_CH-1:0] en;
  } fault_ctrl_t;

  typedef logic [NUM_CH-1:0][NUM_PHASE-1:0] pattern_t;

  typedef enum logic [SEL_W-1:0] {
    SEL_FAULT = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_VAL   = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/pwm_out_regs.sv
module pwm_out_regs
  import pwm_out_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     por_rst,
  input  logic                     sys_rst,
  input  logic [FC_W-1:0]          cfg_default,
  input  logic                     wr_en,
  input  logic [SEL_W-1:0]         wr_sel,
  input  logic [DATA_W-1:0]        wr_data,
  output fault_ctrl_t              fc_q,
  output logic                     ovr_q,
  output logic                     ramp_q,
  output pattern_t                 val_q
);

  always_ff @(posedge clk) begin
    if (por_rst) begin
      fc_q   <= '0;
      ovr_q  <= 1'b0;
      ramp_q <= 1'b0;
      val_q  <= '0;
    end else if (sys_rst) begin
      fc_q   <= fault_ctrl_t'(cfg_default);
      ovr_q  <= 1'b0;
      ramp_q <= 1'b0;
      val_q  <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        SEL_FAULT: fc_q <= fault_ctrl_t'(wr_data[FC_W-1:0]);
        SEL_CTRL: begin
          ovr_q  <= wr_data[0];
          ramp_q <= wr_data[1];
        end
        SEL_VAL:  val_q <= pattern_t'(wr_data[VAL_W-1:0]);
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pwm_wave_gen.sv
module pwm_wave_gen
  import pwm_out_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               phase_valid,
  input  logic [PHASE_W-1:0] phase,
  input  logic               ovr,
  input  logic               ramp,
  input  pattern_t           val,
  output logic [NUM_CH-1:0]  wave_q
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam logic [PHASE_W-1:0] ON_PH = PHASE_W'(2 * ch + 1);
    logic own_phase;
    logic nxt;
    logic lvl_q;

    // Phases 2*ch and 2*ch+1 belong to this channel.
    assign own_phase = (phase[PHASE_W-1:1] == (PHASE_W-1)'(ch));
    assign nxt       = ovr ? val[ch][phase] : (phase == ON_PH);

    always_ff @(posedge clk) begin
      if (rst) begin
        lvl_q <= 1'b0;
      end else if (phase_valid && (!ramp || own_phase)) begin
        lvl_q <= nxt;
      end
    end

    assign wave_q[ch] = lvl_q;
  end

endmodule

// File: rtl/pwm_fault_force.sv
module pwm_fault_force
  import pwm_out_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              fault_in,
  input  logic              phase_valid,
  input  fault_ctrl_t       fc,
  input  logic [NUM_CH-1:0] wave,
  input  logic              ovr,
  input  pattern_t          val,
  output logic [NUM_CH-1:0] wo,
  output logic [NUM_CH-1:0] oe,
  output logic              warn
);

  logic              fault_q;
  logic              hold_q;
  logic              forced;
  logic [NUM_CH-1:0] mism;

  // hold_q keeps the safe levels after a reset or a fault until a
  // phase update arrives with the registered fault flag low.
  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q <= 1'b0;
      hold_q  <= 1'b1;
    end else begin
      fault_q <= fault_in;
      if (fault_q) begin
        hold_q <= 1'b1;
      end else if (phase_valid) begin
        hold_q <= 1'b0;
      end
    end
  end

  assign forced = fault_q | hold_q;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_out
    assign wo[ch]   = fc.en[ch] & (forced ? fc.lvl[ch] : wave[ch]);
    assign oe[ch]   = fc.en[ch];
    assign mism[ch] = (fc.lvl[ch] != val[ch][0]) | (fc.lvl[ch] != val[ch][2]);
  end

  assign warn = ovr & (|mism);

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
  import pwm_out_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               por_rst,
  input  logic               sys_rst,
  input  logic [FC_W-1:0]    cfg_default,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               phase_valid,
  input  logic [PHASE_W-1:0] phase,
  input  logic               fault_in,
  output logic               wo_a,
  output logic               wo_b,
  output logic               oe_a,
  output logic               oe_b,
  output logic               polarity_warn
);

  logic              any_rst;
  fault_ctrl_t       fc_q;
  logic              ovr_q;
  logic              ramp_q;
  pattern_t          val_q;
  logic [NUM_CH-1:0] wave_q;
  logic [NUM_CH-1:0] wo;
  logic [NUM_CH-1:0] oe;

  assign any_rst = por_rst | sys_rst;

  pwm_out_regs #(.DATA_W(DATA_W)) regs_i (
    .clk         (clk),
    .por_rst     (por_rst),
    .sys_rst     (sys_rst),
    .cfg_default (cfg_default),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .fc_q        (fc_q),
    .ovr_q       (ovr_q),
    .ramp_q      (ramp_q),
    .val_q       (val_q)
  );

  pwm_wave_gen wave_i (
    .clk         (clk),
    .rst         (any_rst),
    .phase_valid (phase_valid),
    .phase       (phase),
    .ovr         (ovr_q),
    .ramp        (ramp_q),
    .val         (val_q),
    .wave_q      (wave_q)
  );

  pwm_fault_force force_i (
    .clk         (clk),
    .rst         (any_rst),
    .fault_in    (fault_in),
    .phase_valid (phase_valid),
    .fc          (fc_q),
    .wave        (wave_q),
    .ovr         (ovr_q),
    .val         (val_q),
    .wo          (wo),
    .oe          (oe),
    .warn        (polarity_warn)
  );

  assign wo_a = wo[0];
  assign wo_b = wo[1];
  assign oe_a = oe[0];
  assign oe_b = oe[1];

endmodule

// File: rtl/pwm_out_stage_chk.sv
module pwm_out_stage_chk
  import pwm_out_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic               clk,
  input logic               por_rst,
  input logic               sys_rst,
  input logic               wr_en,
  input logic [SEL_W-1:0]   wr_sel,
  input logic [DATA_W-1:0]  wr_data,
  input logic               phase_valid,
  input logic [PHASE_W-1:0] phase,
  input logic               fault_in,
  input logic               wo_a,
  input logic               wo_b,
  input logic               oe_a,
  input logic               oe_b,
  input logic               polarity_warn,
  input fault_ctrl_t        fc_q,
  input logic               ovr_q,
  input logic               ramp_q,
  input pattern_t           val_q,
  input logic [NUM_CH-1:0]  wave_q
);

  // R1
  por_clear_chk: assert property (@(posedge clk) disable iff (sys_rst)
    por_rst |=> (!oe_a && !oe_b && !wo_a && !wo_b));

  // R8
  fault_force_chk: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
    (fault_in && !wr_en) |=>
      (wo_a == (fc_q.en[0] & fc_q.lvl[0])) && (wo_b == (fc_q.en[1] & fc_q.lvl[1])));

  // R10
  oe_write_chk: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
    (wr_en && wr_sel == SEL_W'(0)) |=> (oe_a == $past(wr_data[0])) && (oe_b == $past(wr_data[1])));

  // R9
  warn_mismatch_chk: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
    (ovr_q && (fc_q.lvl[0] != val_q[0][0])) |-> polarity_warn);

  // R7
  ramp_hold_chk: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
    (phase_valid && ramp_q && phase[1]) |=> (wave_q[0] == $past(wave_q[0])));

  // R6
  ovr_level_chk: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
    (phase_valid && ovr_q && !ramp_q) |=> (wave_q[0] == $past(val_q[0][phase])));

  // R5
  normal_gen_chk: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
    (phase_valid && !ovr_q && !ramp_q) |=> (wave_q[1] == ($past(phase) == PHASE_W'(3))));

endmodule

bind pwm_out_stage pwm_out_stage_chk #(.DATA_W(DATA_W)) chk_i (
  .clk           (clk),
  .por_rst       (por_rst),
  .sys_rst       (sys_rst),
  .wr_en         (wr_en),
  .wr_sel        (wr_sel),
  .wr_data       (wr_data),
  .phase_valid   (phase_valid),
  .phase         (phase),
  .fault_in      (fault_in),
  .wo_a          (wo_a),
  .wo_b          (wo_b),
  .oe_a          (oe_a),
  .oe_b          (oe_b),
  .polarity_warn (polarity_warn),
  .fc_q          (fc_q),
  .ovr_q         (ovr_q),
  .ramp_q        (ramp_q),
  .val_q         (val_q),
  .wave_q        (wave_q)
);

// File: tb/pwm_out_stage_tb.sv
module pwm_out_stage_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam logic [3:0] CFG = 4'b1011; // en A, en B, lvl A=0, lvl B=1
  localparam int NVEC = 16;
  // [13] ovr [12] ramp [11:8] pattern A [7:4] pattern B [3:2] phase [1] exp A [0] exp B
  localparam logic [13:0] VECS [NVEC] = '{
    {1'b0, 1'b0, 4'b0000, 4'b0000, 2'd0, 1'b0, 1'b0},
    {1'b0, 1'b0, 4'b0000, 4'b0000, 2'd1, 1'b1, 1'b0},
    {1'b0, 1'b0, 4'b0000, 4'b0000, 2'd2, 1'b0, 1'b0},
    {1'b0, 1'b0, 4'b0000, 4'b0000, 2'd3, 1'b0, 1'b1},
    {1'b1, 1'b0, 4'b1010, 4'b0101, 2'd0, 1'b0, 1'b1},
    {1'b1, 1'b0, 4'b1010, 4'b0101, 2'd1, 1'b1, 1'b0},
    {1'b1, 1'b0, 4'b1010, 4'b0101, 2'd2, 1'b0, 1'b1},
    {1'b1, 1'b0, 4'b1010, 4'b0101, 2'd3, 1'b1, 1'b0},
    {1'b0, 1'b1, 4'b0000, 4'b0000, 2'd1, 1'b1, 1'b0},
    {1'b0, 1'b1, 4'b0000, 4'b0000, 2'd3, 1'b1, 1'b1},
    {1'b0, 1'b1, 4'b0000, 4'b0000, 2'd2, 1'b1, 1'b0},
    {1'b0, 1'b1, 4'b0000, 4'b0000, 2'd0, 1'b0, 1'b0},
    {1'b1, 1'b1, 4'b0110, 4'b1001, 2'd1, 1'b1, 1'b0},
    {1'b1, 1'b1, 4'b0110, 4'b1001, 2'd3, 1'b1, 1'b1},
    {1'b1, 1'b1, 4'b0110, 4'b1001, 2'd0, 1'b0, 1'b1},
    {1'b1, 1'b1, 4'b0110, 4'b1001, 2'd2, 1'b0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       por_rst = 1'b1;
  logic       sys_rst = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic       phase_valid = 1'b0;
  logic [1:0] phase = '0;
  logic       fault_in = 1'b0;
  logic       wo_a, wo_b, oe_a, oe_b, polarity_warn;
  int         n_checks = 0;
  int         n_errors = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwm_out_stage dut_i (
    .clk (clk), .por_rst (por_rst), .sys_rst (sys_rst), .cfg_default (CFG),
    .wr_en (wr_en), .wr_sel (wr_sel), .wr_data (wr_data),
    .phase_valid (phase_valid), .phase (phase), .fault_in (fault_in),
    .wo_a (wo_a), .wo_b (wo_b), .oe_a (oe_a), .oe_b (oe_b),
    .polarity_warn (polarity_warn)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic write_reg(input logic [1:0] sel, input logic [7:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input logic [1:0] ph);
    phase_valid = 1'b1; phase = ph;
    @(negedge clk);
    phase_valid = 1'b0;
  endtask

  task automatic fault_pulse();
    fault_in = 1'b1;
    @(negedge clk);
    fault_in = 1'b0;
  endtask

  task automatic chk_out(input string req, input logic ea, input logic eb);
    chk(req, "wo_a", wo_a, ea);
    chk(req, "wo_b", wo_b, eb);
  endtask

  initial begin
    for (int cyc = 0; cyc < WATCHDOG; cyc++) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    por_rst = 1'b0;
    // R1: power-on reset clears everything
    chk("R1", "oe_a", oe_a, 1'b0);
    chk("R1", "oe_b", oe_b, 1'b0);
    chk_out("R1", 1'b0, 1'b0);
    chk("R1", "warn", polarity_warn, 1'b0);

    // R2/R3: system reset loads configuration, safe levels until phase update
    sys_rst = 1'b1;
    @(negedge clk);
    sys_rst = 1'b0;
    chk("R2", "oe_a", oe_a, 1'b1);
    chk("R2", "oe_b", oe_b, 1'b1);
    chk_out("R3", 1'b0, 1'b1);
    @(negedge clk);
    chk_out("R3", 1'b0, 1'b1);
    step(2'd1);
    chk_out("R3", 1'b1, 1'b0);

    // R5/R6/R7: vector table with both levels 0, both enabled
    write_reg(2'd0, 8'h03);
    for (int i = 0; i < NVEC; i++) begin
      write_reg(2'd1, {6'd0, VECS[i][12], VECS[i][13]});
      write_reg(2'd2, {VECS[i][7:4], VECS[i][11:8]});
      step(VECS[i][3:2]);
      if (VECS[i][12]) chk_out("R7", VECS[i][1], VECS[i][0]);
      else if (VECS[i][13]) chk_out("R6", VECS[i][1], VECS[i][0]);
      else chk_out("R5", VECS[i][1], VECS[i][0]);
    end

    // R8: fault forcing, hold, release
    write_reg(2'd1, 8'h00);
    write_reg(2'd0, 8'h0F);
    step(2'd0);
    chk_out("R8", 1'b0, 1'b0);
    fault_pulse();
    chk_out("R8", 1'b1, 1'b1);
    @(negedge clk);
    chk_out("R8", 1'b1, 1'b1);
    step(2'd0);
    chk_out("R8", 1'b0, 1'b0);

    // R8: priority over override, release needs fault flag already low
    write_reg(2'd1, 8'h01);
    write_reg(2'd2, 8'h00);
    step(2'd1);
    chk_out("R6", 1'b0, 1'b0);
    fault_pulse();
    chk_out("R8", 1'b1, 1'b1);
    step(2'd1);
    chk_out("R8", 1'b1, 1'b1);
    step(2'd1);
    chk_out("R8", 1'b0, 1'b0);

    // R9: polarity warning, levels both 1, override on
    write_reg(2'd2, 8'h55);
    chk("R9", "warn", polarity_warn, 1'b0);
    write_reg(2'd2, 8'h45);
    chk("R9", "warn", polarity_warn, 1'b1);
    write_reg(2'd1, 8'h00);
    chk("R9", "warn", polarity_warn, 1'b0);

    // R10: select 3 writes nothing
    write_reg(2'd3, 8'hF0);
    chk("R10", "oe_a", oe_a, 1'b1);
    chk("R10", "oe_b", oe_b, 1'b1);
    write_reg(2'd1, 8'h01);
    chk("R10", "warn", polarity_warn, 1'b1);

    // R4: disabled outputs stay low, even in a fault
    write_reg(2'd0, 8'h0C);
    chk("R4", "oe_a", oe_a, 1'b0);
    chk("R4", "oe_b", oe_b, 1'b0);
    chk_out("R4", 1'b0, 1'b0);
    fault_pulse();
    chk_out("R4", 1'b0, 1'b0);

    // R2: system reset overrides software contents and clears control
    write_reg(2'd0, 8'h00);
    sys_rst = 1'b1;
    @(negedge clk);
    sys_rst = 1'b0;
    chk("R2", "oe_a", oe_a, 1'b1);
    chk("R2", "warn", polarity_warn, 1'b0);
    chk_out("R3", 1'b0, 1'b1);

    // R1: power-on reset clears the configuration-loaded value
    por_rst = 1'b1;
    @(negedge clk);
    por_rst = 1'b0;
    chk("R1", "oe_a", oe_a, 1'b0);
    chk("R1", "oe_b", oe_b, 1'b0);
    chk_out("R1", 1'b0, 1'b0);

    finish_run();
  end
endmodule